// File: doc/BRIEF.md
# Preamble Presence Detector and Symbol Timing Peak Finder

This block sits after the metric generators of a burst receiver. On every sample strobe it receives two non-negative metrics: the magnitude of the sliding autocorrelation between the two halves of the receive window, and the energy-match metric. The energy-match metric correlates received power against the known power profile of the preamble. The block first decides whether a preamble is present. It declares a frame once the autocorrelation magnitude exceeds a programmable fraction of the energy-match metric on a run of consecutive samples.

Once a frame is declared, the block opens a search window one preamble period long. Over that window it looks for the largest value of the current energy-match metric plus the value the metric had one period earlier. When the window closes, it reports the sample index of that largest value as the first sample of the transform window. The index then stays on the output until the block is rearmed for the next burst. Computing the metrics and correcting frequency are left to neighbouring blocks.

Top module: `preamble_timing_sync`

## Requirements
- R1: After reset, `detect_pulse` and `timing_vld` are low and `timing_idx` is 0.
- R2: A sample is a threshold hit when `auto_mag * 2^THR_FRAC > nrg_metric * thr_frac`, with `thr_frac` unsigned and holding THR_FRAC = 4 fractional bits. Equality is not a hit.
- R3: While no frame is declared, `detect_pulse` pulses for one cycle after the RUN_LEN-th (4th) consecutive hit. The pulse appears in the cycle after the clock edge that captured that sample. A non-hit sample sets the run back to zero.
- R4: Cycles with `smp_vld` low carry no sample. They neither add to a run nor break it, and they do not advance the search window.
- R5: The search window covers the PERIOD (64) valid samples that follow the detecting sample. `timing_vld` pulses for one cycle after the edge that captured the last of them.
- R6: The search term is the current `nrg_metric` plus the `nrg_metric` seen PERIOD valid samples earlier. That earlier value counts as 0 while fewer than PERIOD samples have arrived since reset.
- R7: When several samples of the window share the largest search term, the earliest of them is reported.
- R8: Every valid sample has an index. The index is the number of valid samples since reset, so the first sample is index 0. `timing_idx` reports the index of the chosen sample.
- R9: After `timing_vld`, the block does not evaluate samples and gives no further detection until `rearm` is asserted. `timing_idx` holds its value until the next `timing_vld`. After rearm, the hit run starts from zero.
- R10: `rearm` has no effect unless a timing result has been reported and not yet rearmed.
- R11: `thr_frac` = 8 sets a threshold of one half. A hit is then `2 * auto_mag > nrg_metric`, and the product reduces to a single shifted copy of the metric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe for both metrics |
| auto_mag | input | MAG_W | Autocorrelation magnitude |
| nrg_metric | input | NRG_W | Energy-match metric |
| thr_frac | input | THR_W | Threshold fraction, unsigned with THR_FRAC fractional bits |
| rearm | input | 1 | Return from the reported state to detection |
| detect_pulse | output | 1 | One-cycle frame detection pulse |
| timing_vld | output | 1 | One-cycle pulse: timing result ready |
| timing_idx | output | IDX_W | Sample index of the search maximum |

## Verification
The bench feeds runs of three hits that end in a miss or in an exact-equality sample. A design that counts non-consecutive hits, or treats equality as a hit, would detect too early. It puts strobe gaps inside a run and inside the search window, which a design that counted idle cycles as samples would mishandle. It places two equal maxima inside one window, where a non-strict compare would report the later one. It also places a lone energy spike one period before the window, so the peak only lands correctly if the delayed term is added. Finally, it sends hits after the result and pulses rearm in the middle of a run, to catch a design that re-detects without rearm or that reacts to an early rearm.

// File: rtl/psync_pkg.sv
package psync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DONE   = 2'd3
    } psync_state_e;
endpackage

// File: rtl/psync_thr_cmp.sv
module psync_thr_cmp #(
    parameter int MAG_W    = 16,
    parameter int NRG_W    = 16,
    parameter int THR_W    = 5,
    parameter int THR_FRAC = 4
) (
    input  logic [MAG_W-1:0] mag_i,
    input  logic [NRG_W-1:0] nrg_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             hit_o
);
    localparam int PROD_W = NRG_W + THR_W;
    localparam int LHS_W  = MAG_W + THR_FRAC;
    localparam int CMP_W  = ((PROD_W > LHS_W) ? PROD_W : LHS_W) + 1;

    logic [PROD_W-1:0] part [THR_W];
    logic [PROD_W-1:0] prod;

    // one shifted copy of the metric per set threshold bit
    for (genvar k = 0; k < THR_W; k++) begin : g_part
        assign part[k] = thr_i[k] ? (PROD_W'(nrg_i) << k) : '0;
    end

    always_comb begin
        prod = '0;
        for (int k = 0; k < THR_W; k++) begin
            prod = prod + part[k];
        end
    end

    assign hit_o = (CMP_W'(mag_i) << THR_FRAC) > CMP_W'(prod);
endmodule

// File: rtl/psync_dly.sv
module psync_dly #(
    parameter int W     = 16,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stage_q[k] <= '0;
                else if (en) stage_q[k] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)  stage_q[k] <= '0;
                else if (en) stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/psync_peak_sel.sv
module psync_peak_sel #(
    parameter int SUM_W = 17
) (
    input  logic             first_i,
    input  logic [SUM_W-1:0] cand_i,
    input  logic [SUM_W-1:0] best_i,
    output logic             take_o
);
    // strict compare: a tie leaves the earlier sample in place
    assign take_o = first_i || (cand_i > best_i);
endmodule

// File: rtl/preamble_timing_sync.sv
module preamble_timing_sync
    import psync_pkg::*;
#(
    parameter int MAG_W    = 16,
    parameter int NRG_W    = 16,
    parameter int THR_W    = 5,
    parameter int THR_FRAC = 4,
    parameter int PERIOD   = 64,
    parameter int RUN_LEN  = 4,
    parameter int IDX_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [MAG_W-1:0] auto_mag,
    input  logic [NRG_W-1:0] nrg_metric,
    input  logic [THR_W-1:0] thr_frac,
    input  logic             rearm,
    output logic             detect_pulse,
    output logic             timing_vld,
    output logic [IDX_W-1:0] timing_idx
);
    localparam int SUM_W = NRG_W + 1;
    localparam int WIN_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int HLF_W = ((MAG_W > NRG_W) ? MAG_W : NRG_W) + 2;
    localparam logic [THR_W-1:0] THR_HALF = THR_W'(1 << (THR_FRAC - 1));

    typedef struct packed {
        psync_state_e     state;
        logic [RUN_W-1:0] run;
        logic [WIN_W-1:0] win;
        logic [IDX_W-1:0] cnt;
        logic [SUM_W-1:0] best;
        logic [IDX_W-1:0] best_idx;
        logic             det;
        logic             tvld;
        logic [IDX_W-1:0] idx;
    } psync_reg_t;

    psync_reg_t r_q, r_d;

    logic             hit;
    logic [NRG_W-1:0] nrg_old;
    logic [SUM_W-1:0] cand;
    logic             take;

    psync_thr_cmp #(
        .MAG_W(MAG_W), .NRG_W(NRG_W), .THR_W(THR_W), .THR_FRAC(THR_FRAC)
    ) u_thr (
        .mag_i(auto_mag), .nrg_i(nrg_metric), .thr_i(thr_frac), .hit_o(hit)
    );

    psync_dly #(.W(NRG_W), .DEPTH(PERIOD)) u_dly (
        .clk(clk), .rst_n(rst_n), .en(smp_vld), .din(nrg_metric), .dout(nrg_old)
    );

    assign cand = SUM_W'(nrg_metric) + SUM_W'(nrg_old);

    psync_peak_sel #(.SUM_W(SUM_W)) u_peak (
        .first_i(r_q.win == '0), .cand_i(cand), .best_i(r_q.best), .take_o(take)
    );

    always_comb begin
        r_d      = r_q;
        r_d.det  = 1'b0;
        r_d.tvld = 1'b0;
        if (smp_vld) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        unique case (r_q.state)
            ST_IDLE, ST_COUNT: begin
                if (smp_vld) begin
                    if (hit) begin
                        if (r_q.run == RUN_W'(RUN_LEN - 1)) begin
                            r_d.state = ST_SEARCH;
                            r_d.run   = '0;
                            r_d.win   = '0;
                            r_d.det   = 1'b1;
                        end else begin
                            r_d.state = ST_COUNT;
                            r_d.run   = r_q.run + 1'b1;
                        end
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.run   = '0;
                    end
                end
            end
            ST_SEARCH: begin
                if (smp_vld) begin
                    if (take) begin
                        r_d.best     = cand;
                        r_d.best_idx = r_q.cnt;
                    end
                    if (r_q.win == WIN_W'(PERIOD - 1)) begin
                        r_d.state = ST_DONE;
                        r_d.tvld  = 1'b1;
                        r_d.idx   = take ? r_q.cnt : r_q.best_idx;
                    end else begin
                        r_d.win = r_q.win + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (rearm) begin
                    r_d.state = ST_IDLE;
                    r_d.run   = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign detect_pulse = r_q.det;
    assign timing_vld   = r_q.tvld;
    assign timing_idx   = r_q.idx;

    // R3: detection is a single-cycle pulse and follows a captured hit
    p_det_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        detect_pulse |=> !detect_pulse);
    p_det_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        detect_pulse |-> $past(smp_vld && hit));
    p_det_opens_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
        detect_pulse |-> (r_q.state == ST_SEARCH));
    // R5: timing result only on entry to the reported state
    p_tvld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timing_vld |-> (r_q.state == ST_DONE) && $past(r_q.state == ST_SEARCH));
    // R9: held index, no detection while waiting for rearm
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_vld |-> $stable(timing_idx));
    p_no_det_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DONE) |=> !detect_pulse);
    // R10: rearm outside the reported state does not move the FSM to idle by itself
    p_rearm_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !smp_vld && r_q.state == ST_COUNT) |=> (r_q.state == ST_COUNT));
    // R11: a half threshold behaves as one shift
    p_half_shift_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_frac == THR_HALF) |->
            (hit == ((HLF_W'(auto_mag) << 1) > HLF_W'(nrg_metric))));
endmodule

// File: tb/tb_preamble_timing_sync.sv
module tb_preamble_timing_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] auto_mag = '0;
    logic [15:0] nrg_metric = '0;
    logic [4:0]  thr_frac = 5'd8;
    logic        rearm = 1'b0;
    logic        detect_pulse, timing_vld;
    logic [15:0] timing_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model state
    int m_mode = 0;   // 0 hunting, 1 searching, 2 reported
    int m_run = 0;
    int m_win = 0;
    int m_cnt = 0;
    longint m_best = 0;
    int m_bidx = 0;
    int m_idx = 0;
    int hist [0:16383];

    always #10 clk = ~clk;

    preamble_timing_sync dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .auto_mag(auto_mag),
        .nrg_metric(nrg_metric), .thr_frac(thr_frac), .rearm(rearm),
        .detect_pulse(detect_pulse), .timing_vld(timing_vld), .timing_idx(timing_idx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int floor_thr(int nrg);
        return (nrg * int'(thr_frac)) / 16;
    endfunction

    function automatic int mk_hit(int nrg);
        return floor_thr(nrg) + 1 + int'($urandom % 4);
    endfunction

    function automatic int mk_miss(int nrg);
        int f = floor_thr(nrg);
        return f - int'($urandom % (f + 1));
    endfunction

    task automatic send(input int mag, input int nrg, input bit rr, input string req);
        bit hit, e_det, e_tv;
        longint sum;
        int k;
        @(negedge clk);
        smp_vld = 1'b1; auto_mag = 16'(mag); nrg_metric = 16'(nrg); rearm = rr;
        k = m_cnt;
        hist[k] = nrg;
        sum = longint'(nrg) + ((k >= 64) ? longint'(hist[k-64]) : 0);
        m_cnt++;
        hit = (longint'(mag) * 16) > (longint'(nrg) * longint'(thr_frac));
        e_det = 0; e_tv = 0;
        if (m_mode == 0) begin
            if (hit) begin
                m_run++;
                if (m_run == 4) begin
                    e_det = 1; m_mode = 1; m_run = 0; m_win = 0;
                end
            end else m_run = 0;
        end else if (m_mode == 1) begin
            if (m_win == 0 || sum > m_best) begin
                m_best = sum; m_bidx = k;
            end
            m_win++;
            if (m_win == 64) begin
                m_mode = 2; e_tv = 1; m_idx = m_bidx;
            end
        end
        @(posedge clk); #5;
        chk(detect_pulse == e_det, {req, " detect"}, detect_pulse, e_det);
        chk(timing_vld == e_tv, {req, " timing_vld"}, timing_vld, e_tv);
        chk(timing_idx == 16'(m_idx), {req, " timing_idx"}, timing_idx, m_idx);
        smp_vld = 1'b0; rearm = 1'b0;
    endtask

    task automatic idle(input int n, input bit rr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rearm = rr;
            @(posedge clk); #5;
            rearm = 1'b0;
            chk(!detect_pulse && !timing_vld, "R4 gap pulses", {detect_pulse, timing_vld}, 0);
        end
    endtask

    task automatic do_rearm();
        @(negedge clk); rearm = 1'b1;
        @(posedge clk); #5; rearm = 1'b0;
        if (m_mode == 2) begin m_mode = 0; m_run = 0; end
    endtask

    task automatic noise(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int nr = int'($urandom % 4096);
            send(mk_miss(nr), nr, 0, req);
        end
    endtask

    initial begin
        int nr, guard;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #5;
        chk(!detect_pulse && !timing_vld && timing_idx == 0, "R1 reset outputs",
            {detect_pulse, timing_vld, timing_idx}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #5;
        chk(!detect_pulse && !timing_vld && timing_idx == 0, "R1 after release",
            {detect_pulse, timing_vld, timing_idx}, 0);

        // R11 half threshold, R3 broken run, R4 gap inside run
        thr_frac = 5'd8;
        noise(10, "R3");
        send(600, 1000, 0, "R11"); send(600, 1000, 0, "R11"); send(600, 1000, 0, "R11");
        send(499, 1000, 0, "R3 miss breaks run");
        send(501, 1000, 0, "R11"); send(501, 1000, 0, "R3");
        idle(3, 0);
        send(501, 1000, 0, "R4"); send(700, 1000, 0, "R3 fourth hit");
        chk(m_mode == 1, "R3 detect reached", m_mode, 1);
        for (int i = 0; i < 64; i++) begin
            send(0, (i == 20) ? 3000 : 10, 0, "R5");
            if (i == 30) idle(2, 0);
        end
        chk(timing_idx == 16'(m_idx), "R8 index of peak", timing_idx, m_idx);

        // R9 no detection while reported, R10 rearm mid-run ignored
        for (int i = 0; i < 8; i++) send(900, 100, 0, "R9 no redetect");
        chk(timing_idx == 16'(m_idx), "R9 index held", timing_idx, m_idx);
        do_rearm();

        // R2 equality is not a hit; R10 rearm during counting
        send(1, 2, 0, "R2"); send(1, 2, 0, "R2");
        send(5, 2, 1, "R10 rearm with hit");
        send(1, 2, 0, "R2 equality miss");
        send(5, 2, 0, "R2"); idle(1, 1); send(5, 2, 0, "R10");
        send(5, 2, 0, "R2"); send(5, 2, 0, "R2 detect");
        chk(m_mode == 1, "R2 detect reached", m_mode, 1);
        // R7 tie inside window: equal maxima at offsets 10 and 40
        for (int i = 0; i < 64; i++)
            send(0, (i == 10 || i == 40) ? 5000 : 3, 0, "R7");
        chk(timing_idx == 16'(m_cnt - 64 + 10), "R7 earlier tie kept", timing_idx,
            m_cnt - 64 + 10);
        do_rearm();

        // R6 delayed term: lone spike one period before the window
        for (int i = 0; i < 60; i++) send(0, (i == 5) ? 9000 : 1, 0, "R6 lead");
        for (int i = 0; i < 4; i++) send(100, 10, 0, "R6 run");
        for (int i = 0; i < 64; i++) send(0, 1, 0, "R6");
        chk(timing_idx == 16'(m_cnt - 128 + 5 + 64), "R6 delayed peak", timing_idx,
            m_cnt - 128 + 5 + 64);
        do_rearm();

        // random trials
        for (int t = 0; t < 30; t++) begin
            thr_frac = (t % 5 == 0) ? 5'd8 : 5'(1 + $urandom % 31);
            guard = 0;
            while (m_mode != 2 && guard < 400) begin
                nr = int'($urandom % 4096);
                if (guard > 120 || ($urandom % 10) < 6) send(mk_hit(nr), nr, 0, "R3 random");
                else send(mk_miss(nr), nr, 0, "R5 random");
                if ($urandom % 16 == 0) idle(1, 0);
                guard++;
            end
            chk(m_mode == 2, "R5 random reached result", m_mode, 2);
            do_rearm();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule